// File: doc/BRIEF.md
# Page-Table DMA Address Translator

This block turns an address issued by a DMA-capable device into a physical memory address. It does this by looking up a single-level page table kept in system memory. Software writes two registers: the table base, and the table limit given in bytes. Each request address is split into a 4 KiB page number and a 12-bit offset. The page number is bounds-checked against the limit. If it is in range, one 8-byte table entry is read over a valid/ready memory read port. The low 32-bit word of that entry holds the page frame, and the upper word holds an owner field that the block does not use.

Only one translation is in flight at a time. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. The memory read request is held until `mem_req_ready` is sampled high. The memory then returns the entry on a later cycle, flagged by `mem_rsp_valid`, with `mem_rsp_err` marking a failed read. The result appears as a one-cycle `rsp_valid` pulse. It carries the page-aligned request address, the physical address, a fixed offset mask and the granted rights. A request that is out of range, or whose entry read fails, gets address zero and no rights.

Top module: `pt_xlate`

## Requirements
- R1: After reset the base and limit registers are zero, so every request faults; `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: The page index is the request address shifted right by 12. A request is in range only when the index is strictly less than the limit register shifted right by 3. Low limit bits below one entry therefore grant nothing.
- R3: For an in-range request, `mem_req_addr` equals the base register with bit 31 forced to 0, plus the index times 8, modulo 2^32.
- R4: On a fetch without error, `rsp_paddr` is bits 31..12 of `mem_rsp_data[31:0]` joined with request bits 11..0. `rsp_perm` is 2'b11, where bit 0 is read and bit 1 is write. `mem_rsp_data[63:32]` has no effect.
- R5: An out-of-range request issues no memory read and returns `rsp_paddr` 0 with `rsp_perm` 2'b00.
- R6: A fetch answered with `mem_rsp_err` = 1 returns `rsp_paddr` 0 with `rsp_perm` 2'b00.
- R7: Every response carries `rsp_iova` equal to the request address with bits 11..0 cleared, and `rsp_mask` equal to 12'hFFF.
- R8: `cfg_wr_en` with byte offset 8'h18 loads the base and with 8'h20 loads the limit. A write to 8'h28 (table invalidate), or to any other offset, changes no translation result.
- R9: `req_ready` is 0 from the cycle after an acceptance until the response has been given. While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays up with `mem_req_addr` unchanged.
- R10: Each accepted request yields exactly one response, and `rsp_valid` is high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_off | input | 8 | Register byte offset |
| cfg_wr_data | input | 32 | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | 32 | Device-side address to translate |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_iova | output | 32 | Request address, page-aligned |
| rsp_paddr | output | 32 | Translated physical address, 0 on fault |
| rsp_mask | output | 12 | Page offset mask, always all ones |
| rsp_perm | output | 2 | Granted rights: bit 0 read, bit 1 write |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry: frame word in bits 31..0, owner word in 63..32 |
| mem_rsp_err | input | 1 | Entry read failed |

## Verification
The bench steps the limit across the entry boundary: limit 64 admits index 7, and limit 63 rejects it. A design that divides the limit by the wrong amount, or compares with less-or-equal, grants a page it must refuse. It also programs a base with bit 31 set and an index large enough to carry the entry address past bit 31. A design that leaves the top bit of the base in place, or drops the carry, reads the wrong entry, and the memory model flags the unexpected address. A poisoned entry checks that an errored fetch returns a frame of zero rather than the data on the bus. A memory model that stalls its ready checks that the request address holds steady. Writes to the invalidate offset and an unmapped offset, followed by a repeat translation, would show any decode that lets them disturb the base or limit.

// File: rtl/xl_pkg.sv
package xl_pkg;
    localparam logic [7:0] OFF_TBL_BASE  = 8'h18;
    localparam logic [7:0] OFF_TBL_LIMIT = 8'h20;
    localparam logic [7:0] OFF_TBL_INVAL = 8'h28;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } walk_st_e;
endpackage

// File: rtl/xl_cfg_regs.sv
module xl_cfg_regs #(
    parameter int unsigned AW  = 32,
    parameter int unsigned CAW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [CAW-1:0] wr_off,
    input  logic [AW-1:0]  wr_data,
    output logic [AW-1:0]  tbl_base,
    output logic [AW-1:0]  tbl_limit
);
    import xl_pkg::*;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] limit;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            // the invalidate offset and all unknown offsets fall through untouched
            if (wr_off == CAW'(OFF_TBL_BASE))  cfg_d.base  = wr_data;
            if (wr_off == CAW'(OFF_TBL_LIMIT)) cfg_d.limit = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign tbl_base  = cfg_q.base;
    assign tbl_limit = cfg_q.limit;

    // R8
    other_off_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_off != CAW'(OFF_TBL_BASE) && wr_off != CAW'(OFF_TBL_LIMIT))
        |=> ($stable(tbl_base) && $stable(tbl_limit)));
endmodule

// File: rtl/xl_index_calc.sv
module xl_index_calc #(
    parameter int unsigned AW      = 32,
    parameter int unsigned PB      = 12,
    parameter int unsigned ENTRY_W = 64
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] tbl_base,
    input  logic [AW-1:0] tbl_limit,
    output logic          in_range,
    output logic [AW-1:0] entry_addr
);
    localparam int unsigned ESH = $clog2(ENTRY_W / 8);
    localparam logic [AW-1:0] BASE_KEEP = {1'b0, {(AW-1){1'b1}}};

    logic [AW-1:0] page_idx;
    logic [AW-1:0] num_entries;

    always_comb begin
        page_idx    = addr >> PB;
        num_entries = tbl_limit >> ESH;
        in_range    = page_idx < num_entries;
        entry_addr  = (tbl_base & BASE_KEEP) + (page_idx << ESH);
    end
endmodule

// File: rtl/xl_walker.sv
module xl_walker #(
    parameter int unsigned AW = 32,
    parameter int unsigned PB = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          in_range,
    input  logic [AW-1:0] entry_addr,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_iova,
    output logic [AW-1:0] rsp_paddr,
    output logic [1:0]    rsp_perm,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [AW-PB-1:0] mem_frame,
    input  logic          mem_rsp_err
);
    import xl_pkg::*;

    typedef struct packed {
        walk_st_e      st;
        logic [AW-1:0] iova;
        logic [AW-1:0] eaddr;
        logic [AW-1:0] paddr;
        logic [PB-1:0] off;
        logic [1:0]    perm;
    } walk_t;

    walk_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        unique case (w_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    w_d.iova  = {req_addr[AW-1:PB], {PB{1'b0}}};
                    w_d.off   = req_addr[PB-1:0];
                    w_d.eaddr = entry_addr;
                    w_d.paddr = '0;
                    w_d.perm  = 2'b00;
                    w_d.st    = in_range ? ST_FETCH : ST_RESP;
                end
            end
            ST_FETCH: if (mem_req_ready) w_d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        w_d.paddr = '0;
                        w_d.perm  = 2'b00;
                    end else begin
                        w_d.paddr = {mem_frame, w_q.off};
                        w_d.perm  = 2'b11;
                    end
                    w_d.st = ST_RESP;
                end
            end
            default: w_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '{st: ST_IDLE, default: '0};
        else        w_q <= w_d;
    end

    assign req_ready     = (w_q.st == ST_IDLE);
    assign mem_req_valid = (w_q.st == ST_FETCH);
    assign mem_req_addr  = w_q.eaddr;
    assign rsp_valid     = (w_q.st == ST_RESP);
    assign rsp_iova      = w_q.iova;
    assign rsp_paddr     = w_q.paddr;
    assign rsp_perm      = w_q.perm;

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R9
    mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    // R10
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R5
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_perm == 2'b00) |-> (rsp_paddr == '0));
    // R4
    perm_both_or_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_perm == 2'b00 || rsp_perm == 2'b11));
    // R6
    err_gives_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && mem_rsp_err && !mem_req_valid && !req_ready && !rsp_valid)
        |=> (rsp_valid && rsp_perm == 2'b00));
endmodule

// File: rtl/pt_xlate.sv
module pt_xlate #(
    parameter int unsigned AW      = 32,
    parameter int unsigned PB      = 12,
    parameter int unsigned ENTRY_W = 64,
    parameter int unsigned CAW     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [CAW-1:0]     cfg_wr_off,
    input  logic [AW-1:0]      cfg_wr_data,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [AW-1:0]      req_addr,
    output logic               rsp_valid,
    output logic [AW-1:0]      rsp_iova,
    output logic [AW-1:0]      rsp_paddr,
    output logic [PB-1:0]      rsp_mask,
    output logic [1:0]         rsp_perm,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [AW-1:0]      mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    input  logic               mem_rsp_err
);
    logic [AW-1:0] tbl_base, tbl_limit, entry_addr;
    logic          in_range;
    logic          unused_entry_bits;

    // owner word and frame low bits are not used by the translation
    assign unused_entry_bits = ^{mem_rsp_data[ENTRY_W-1:AW], mem_rsp_data[PB-1:0]};
    assign rsp_mask = {PB{1'b1}};

    xl_cfg_regs #(.AW(AW), .CAW(CAW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_off(cfg_wr_off),
        .wr_data(cfg_wr_data), .tbl_base(tbl_base), .tbl_limit(tbl_limit)
    );

    xl_index_calc #(.AW(AW), .PB(PB), .ENTRY_W(ENTRY_W)) u_idx (
        .addr(req_addr), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
        .in_range(in_range), .entry_addr(entry_addr)
    );

    xl_walker #(.AW(AW), .PB(PB)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .in_range(in_range), .entry_addr(entry_addr),
        .rsp_valid(rsp_valid), .rsp_iova(rsp_iova), .rsp_paddr(rsp_paddr),
        .rsp_perm(rsp_perm),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_frame(mem_rsp_data[AW-1:PB]), .mem_rsp_err(mem_rsp_err)
    );

    // R7
    iova_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_iova[PB-1:0] == '0));
endmodule

// File: tb/sim_pt_xlate.sv
`timescale 1ns/1ps
module sim_pt_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_off = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_iova, rsp_paddr;
    logic [11:0] rsp_mask;
    logic [1:0]  rsp_perm;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;

    always #4 clk = ~clk;

    pt_xlate u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_off(cfg_wr_off),
        .cfg_wr_data(cfg_wr_data), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_iova(rsp_iova),
        .rsp_paddr(rsp_paddr), .rsp_mask(rsp_mask), .rsp_perm(rsp_perm),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err)
    );

    typedef struct {
        logic [31:0] iova;
        logic [31:0] paddr;
        logic [1:0]  perm;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] eaddr_q[$];
    int          checks = 0;
    int          fails = 0;
    int          rsp_seen = 0;
    logic [31:0] sh_base = '0, sh_limit = '0;
    logic [31:0] err_addr = '0;
    logic        err_on = 1'b0;
    int          mem_stall = 0;

    function automatic logic [63:0] entry_of(logic [31:0] a);
        logic [31:0] fr;
        fr = (a * 32'h9E3779B1) ^ 32'hA5C3_0000;
        return {~fr, fr};
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic cfg_write(logic [7:0] off, logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_off = off; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (off == 8'h18) sh_base = data;
        if (off == 8'h20) sh_limit = data;
    endtask

    task automatic translate(logic [31:0] a, string tag);
        logic [31:0] idx, ea;
        logic [63:0] ent;
        bit          inr, bad;
        exp_t        e;
        idx = a >> 12;
        inr = idx < (sh_limit >> 3);
        ea  = {1'b0, sh_base[30:0]} + (idx << 3);
        ent = entry_of(ea);
        bad = err_on && (ea == err_addr);
        e.iova  = {a[31:12], 12'h000};
        e.paddr = (inr && !bad) ? {ent[31:12], a[11:0]} : 32'h0;
        e.perm  = (inr && !bad) ? 2'b11 : 2'b00;
        e.tag   = tag;
        exp_q.push_back(e);
        if (inr) eaddr_q.push_back(ea);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0; req_addr = 32'hDEAD_BEEF;
        // R9 busy right after acceptance
        check(!req_ready, "R9 req_ready after accept", {63'b0, req_ready}, 64'h0);
        while (!req_ready) @(negedge clk);
    endtask

    // memory model
    initial begin
        int mst = 0;
        int wait_n = 0;
        logic [31:0] cap;
        forever begin
            @(negedge clk);
            case (mst)
                0: if (rst_n && mem_req_valid) begin
                       if (wait_n < mem_stall) wait_n++;
                       else begin
                           mem_req_ready = 1'b1;
                           cap = mem_req_addr;
                           wait_n = 0;
                           mst = 1;
                       end
                   end
                1: begin
                       mem_req_ready = 1'b0;
                       // R3 entry address
                       if (eaddr_q.size() == 0)
                           check(1'b0, "R5 unexpected mem read", {32'h0, cap}, 64'h0);
                       else begin
                           logic [31:0] x;
                           x = eaddr_q.pop_front();
                           check(cap == x, "R3 entry address", {32'h0, cap}, {32'h0, x});
                       end
                       mem_rsp_valid = 1'b1;
                       mem_rsp_data  = (err_on && cap == err_addr) ? 64'hFFFF_FFFF_FFFF_FFFF : entry_of(cap);
                       mem_rsp_err   = err_on && (cap == err_addr);
                       mst = 2;
                   end
                default: begin
                       mem_rsp_valid = 1'b0;
                       mem_rsp_err   = 1'b0;
                       mst = 0;
                   end
            endcase
        end
    end

    // monitor / scoreboard
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                // R10 single-cycle strobe
                if (prev && rsp_valid)
                    check(1'b0, "R10 rsp_valid held", 64'h1, 64'h0);
                if (rsp_valid) begin
                    rsp_seen++;
                    if (exp_q.size() == 0)
                        check(1'b0, "R10 extra response", {32'h0, rsp_paddr}, 64'h0);
                    else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(rsp_paddr == e.paddr, {e.tag, " paddr"}, {32'h0, rsp_paddr}, {32'h0, e.paddr});
                        check(rsp_perm == e.perm, {e.tag, " perm"}, {62'h0, rsp_perm}, {62'h0, e.perm});
                        check(rsp_iova == e.iova && rsp_mask == 12'hFFF, "R7 iova/mask",
                              {20'h0, rsp_mask, rsp_iova}, {20'h0, 12'hFFF, e.iova});
                    end
                end
                prev = rsp_valid;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready && !rsp_valid && !mem_req_valid, "R1 reset outputs",
              {61'h0, req_ready, rsp_valid, mem_req_valid}, 64'h4);
        translate(32'h0000_1234, "R1 fault at reset");

        cfg_write(8'h18, 32'h0001_0000);
        cfg_write(8'h20, 32'h0000_0040);
        translate(32'h0000_0ABC, "R4 index 0");
        translate(32'h0000_7FFF, "R2 last index");
        translate(32'h0000_8000, "R2 first out");
        translate(32'h1234_5678, "R5 far out");

        cfg_write(8'h20, 32'h0000_003F);
        translate(32'h0000_7001, "R2 partial entry");
        translate(32'h0000_6FFF, "R2 index 6");

        cfg_write(8'h18, 32'hFFFF_F000);
        cfg_write(8'h20, 32'hFFFF_FFFF);
        mem_stall = 3;
        translate(32'h0030_0123, "R3 masked base carry");
        translate(32'hFFFF_FFFF, "R9 stalled top page");
        mem_stall = 0;

        cfg_write(8'h18, 32'h0001_0000);
        cfg_write(8'h20, 32'h0000_0040);
        err_addr = 32'h0001_0028; err_on = 1'b1;
        translate(32'h0000_5ABC, "R6 fetch error");
        translate(32'h0000_4ABC, "R4 neighbour ok");
        err_on = 1'b0;

        cfg_write(8'h28, 32'h0000_0000);
        cfg_write(8'h24, 32'h0000_0000);
        cfg_write(8'h1C, 32'h0000_0000);
        translate(32'h0000_1FFF, "R8 after invalidate");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0 && eaddr_q.size() == 0, "R10 all answered",
              {32'h0, 32'(exp_q.size())}, 64'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule